// File: doc/BRIEF.md
# Two-Layout Register Address Decoder with Auto-Advancing Pointer

This unit sits between a byte-level host bus and a dual-port register file that holds eleven registers for each port. Each transaction opens with a start pulse. A control byte follows, carrying a device identity and a read/write flag. Next comes a register address byte, which loads an internal pointer. After that the transaction carries any number of data bytes (writes) or read strobes (reads). For every data beat the unit translates the pointer into a port and a register index, presents them on the select outputs, and can then advance the pointer.

Two address layouts exist, and a configuration register held inside the unit chooses between them at run time. In the interleaved layout, each A/B register pair takes two adjacent addresses. In the split layout, port A registers sit in the lower block and port B registers sit in a block one stride higher. A new layout takes effect on the very next byte, so a pointer that auto-advances can land on an address the new layout leaves unused. Such accesses are flagged, write nothing, and read back zero. The device address check compares the control byte against the three strap pins, or against zero when hardware addressing is off.

Top module: `bank_addr_dec`

## Requirements
- R1: After reset the pointer is 0x00 and the configuration byte is 0x00, which selects the interleaved layout, pointer advance on and hardware addressing off. No select is issued for bytes that arrive before the first start pulse.
- R2: Interleaved layout (configuration bit 7 = 0): an address a ≤ 0x15 selects port a[0] (0 = A, 1 = B) and register index a[4:1]. Any larger address is invalid.
- R3: Split layout (configuration bit 7 = 1): an address with a[7:5] = 0 and a[3:0] ≤ 10 selects port a[4] and index a[3:0]. Every other address is invalid.
- R4: Register index 5 of either port is the configuration byte. It is held inside the unit, never asserted on the select outputs, and returned on rd_data_o when read. Bit 7 selects the layout, bit 5 set stops pointer advance, and bit 3 set enables hardware addressing.
- R5: A layout change applies from the byte that follows the configuring byte. Writing 0x80 to 0x0A in the interleaved layout leaves the pointer at 0x0B, and the next access there is invalid.
- R6: After each data beat the pointer advances by one when configuration bit 5 is 0 and stays put when it is 1. The bit value in force when the beat arrives is the one used.
- R7: Advancing from the last valid address of the current layout (0x15 interleaved, 0x1A split) wraps the pointer to 0x00.
- R8: An access to an invalid address raises inv_o, issues no select, leaves the configuration unchanged, and returns 0x00 on reads.
- R9: A control byte matches only when bits [7:4] = 0x4 and bits [3:1] equal the strap pins (hardware addressing on) or 0 (off). Bit 0 = 1 means read. After a mismatch the unit ignores every byte and strobe, and leaves the pointer untouched, until the next start.
- R10: A read strobe in a matched read transaction raises rd_vld_o in the same cycle and returns rd_data_i for a valid non-configuration register.
- R11: Read strobes in a write transaction and data bytes in a read transaction cause no access and do not move the pointer.
- R12: The byte that follows a matched control byte loads the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Device address strap pins |
| start_i | input | 1 | Start of a transaction |
| byte_vld_i | input | 1 | Host byte valid (control, address or write data) |
| byte_i | input | 8 | Host byte |
| rd_stb_i | input | 1 | Read data strobe |
| rd_data_i | input | 8 | Read data from the register file |
| sel_vld_o | output | 1 | Register file access this cycle |
| sel_we_o | output | 1 | Access is a write |
| sel_port_o | output | 1 | Selected port (0 = A, 1 = B) |
| sel_idx_o | output | 4 | Selected register index |
| sel_wdata_o | output | 8 | Write data |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data to host |
| inv_o | output | 1 | Current access hits an invalid address |
| ptr_o | output | 8 | Current address pointer |
| cfg_o | output | 8 | Configuration byte |

## Verification
Properties check on every cycle that the pointer steps, holds or wraps according to the advance bit and the current layout. They also check that invalid accesses never raise a select, never alter the configuration and read as zero, that a mismatched transaction stays silent, and that split-layout indices stay in range. What only the directed scenarios can show is the address-to-port/index mapping for each layout, the layout switch landing on 0x0B, the configuration register appearing at both of its addresses, and device matching with hardware addressing on and off.

// File: rtl/bank_addr_dec_pkg.sv
package bank_addr_dec_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;

  localparam int CFG_IDX      = 5;
  localparam int CFG_BANK_BIT = 7;
  localparam int CFG_HOLD_BIT = 5;
  localparam int CFG_HAEN_BIT = 3;
endpackage

// File: rtl/bank_map.sv
module bank_map #(
  parameter int AW          = 8,
  parameter int NREG        = 11,
  parameter int IDXW        = 4,
  parameter int OFFW        = 4,
  parameter logic [AW-1:0] PAIRED_LAST = '0
) (
  input  logic [AW-1:0]   addr,
  input  logic            bank,
  output logic            hit,
  output logic            port,
  output logic [IDXW-1:0] idx,
  output logic            is_cfg
);
  import bank_addr_dec_pkg::*;

  always_comb begin
    if (bank) begin
      hit  = ((addr >> (OFFW + 1)) == '0) && (addr[OFFW-1:0] < OFFW'(NREG));
      port = addr[OFFW];
      idx  = addr[IDXW-1:0];
    end else begin
      hit  = (addr <= PAIRED_LAST);
      port = addr[0];
      idx  = addr[IDXW:1];
    end
    is_cfg = hit && (idx == IDXW'(CFG_IDX));
  end
endmodule

// File: rtl/ptr_step.sv
module ptr_step #(
  parameter int AW = 8,
  parameter logic [AW-1:0] PAIRED_LAST = '0,
  parameter logic [AW-1:0] SPLIT_LAST  = '0
) (
  input  logic [AW-1:0] ptr,
  input  logic          bank,
  input  logic          adv,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] last;

  always_comb begin
    last = bank ? SPLIT_LAST : PAIRED_LAST;
    if (!adv)
      nxt = ptr;
    else if (ptr >= last)
      nxt = '0;
    else
      nxt = ptr + 1'b1;
  end
endmodule

// File: rtl/txn_seq.sv
module txn_seq #(
  parameter int DW    = 8,
  parameter int DEVW  = 3,
  parameter logic [DW-DEVW-2:0] DEV_ID = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            byte_vld_i,
  input  logic [DW-1:0]   byte_i,
  input  logic            rd_stb_i,
  input  logic [DEVW-1:0] dev_addr,
  output logic            addr_load,
  output logic            wr_acc,
  output logic            rd_acc
);
  import bank_addr_dec_pkg::*;

  phase_e phase_q, phase_n;
  logic   rd_q, rd_n;
  logic   match;
  logic   adv_en;

  assign match  = (byte_i[DW-1:DEVW+1] == DEV_ID) && (byte_i[DEVW:1] == dev_addr);
  assign adv_en = start_i | byte_vld_i;

  always_comb begin
    phase_n   = phase_q;
    rd_n      = rd_q;
    addr_load = 1'b0;
    wr_acc    = 1'b0;
    rd_acc    = 1'b0;
    if (start_i) begin
      phase_n = PH_CTRL;
    end else begin
      case (phase_q)
        PH_CTRL: if (byte_vld_i) begin
          if (match) begin
            phase_n = PH_ADDR;
            rd_n    = byte_i[0];
          end else begin
            phase_n = PH_SKIP;
          end
        end
        PH_ADDR: if (byte_vld_i) begin
          addr_load = 1'b1;
          phase_n   = PH_DATA;
        end
        PH_DATA: begin
          wr_acc = byte_vld_i & ~rd_q;
          rd_acc = rd_stb_i & rd_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rd_q    <= 1'b0;
    end else if (adv_en) begin
      phase_q <= phase_n;
      rd_q    <= rd_n;
    end
  end

  p_skip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> !(wr_acc || rd_acc || addr_load));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !(wr_acc || rd_acc || addr_load));
endmodule

// File: rtl/bank_addr_dec.sv
module bank_addr_dec #(
  parameter int AW           = 8,
  parameter int DW           = 8,
  parameter int NREG         = 11,
  parameter int SPLIT_STRIDE = 16,
  parameter int DEVW         = 3,
  parameter logic [3:0] DEV_ID = 4'h4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   strap_i,
  input  logic         start_i,
  input  logic         byte_vld_i,
  input  logic [7:0]   byte_i,
  input  logic         rd_stb_i,
  input  logic [7:0]   rd_data_i,
  output logic         sel_vld_o,
  output logic         sel_we_o,
  output logic         sel_port_o,
  output logic [3:0]   sel_idx_o,
  output logic [7:0]   sel_wdata_o,
  output logic         rd_vld_o,
  output logic [7:0]   rd_data_o,
  output logic         inv_o,
  output logic [7:0]   ptr_o,
  output logic [7:0]   cfg_o
);
  import bank_addr_dec_pkg::*;

  localparam int IDXW = $clog2(NREG);
  localparam int OFFW = $clog2(SPLIT_STRIDE);
  localparam logic [AW-1:0] PAIRED_LAST = AW'(2 * NREG - 1);
  localparam logic [AW-1:0] SPLIT_LAST  = AW'(SPLIT_STRIDE + NREG - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [DW-1:0]   cfg_q, cfg_n;
  logic [AW-1:0]   ptr_q, ptr_n, ptr_step_nxt;
  logic            cfg_en, ptr_en;
  logic            bank, hold;
  logic [DEVW-1:0] dev_addr;
  logic            addr_load, wr_acc, rd_acc, acc;
  logic            hit, port, is_cfg;
  logic [IDXW-1:0] idx;

  assign bank     = cfg_q[CFG_BANK_BIT];
  assign hold     = cfg_q[CFG_HOLD_BIT];
  assign dev_addr = cfg_q[CFG_HAEN_BIT] ? strap_i : '0;
  assign acc      = wr_acc | rd_acc;

  txn_seq #(.DW(DW), .DEVW(DEVW), .DEV_ID(DEV_ID)) u_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .rd_stb_i   (rd_stb_i),
    .dev_addr   (dev_addr),
    .addr_load  (addr_load),
    .wr_acc     (wr_acc),
    .rd_acc     (rd_acc)
  );

  bank_map #(.AW(AW), .NREG(NREG), .IDXW(IDXW), .OFFW(OFFW),
             .PAIRED_LAST(PAIRED_LAST)) u_map (
    .addr   (ptr_q),
    .bank   (bank),
    .hit    (hit),
    .port   (port),
    .idx    (idx),
    .is_cfg (is_cfg)
  );

  ptr_step #(.AW(AW), .PAIRED_LAST(PAIRED_LAST), .SPLIT_LAST(SPLIT_LAST)) u_step (
    .ptr  (ptr_q),
    .bank (bank),
    .adv  (acc & ~hold),
    .nxt  (ptr_step_nxt)
  );

  // next state
  always_comb begin
    cfg_en = wr_acc & hit & is_cfg;
    cfg_n  = byte_i;
    ptr_en = addr_load | acc;
    ptr_n  = addr_load ? byte_i : ptr_step_nxt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cfg_q <= '0;
      ptr_q <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_n;
      if (ptr_en) ptr_q <= ptr_n;
    end
  end

  // outputs
  always_comb begin
    sel_vld_o   = acc & hit & ~is_cfg;
    sel_we_o    = wr_acc & hit & ~is_cfg;
    sel_port_o  = port;
    sel_idx_o   = idx;
    sel_wdata_o = byte_i;
    inv_o       = acc & ~hit;
    rd_vld_o    = rd_acc;
    if (!rd_acc || !hit) rd_data_o = '0;
    else if (is_cfg)     rd_data_o = cfg_q;
    else                 rd_data_o = rd_data_i;
  end

  assign ptr_o = ptr_q;
  assign cfg_o = cfg_q;

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc && hold) |=> $stable(ptr_q));

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc && !hold && ptr_q < (bank ? SPLIT_LAST : PAIRED_LAST))
      |=> ptr_q == $past(ptr_q) + 1'b1);

  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc && !hold && ptr_q == (bank ? SPLIT_LAST : PAIRED_LAST)) |=> ptr_q == '0);

  p_inv_nosel_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    inv_o |-> !sel_vld_o);

  p_inv_zero_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (inv_o && rd_vld_o) |-> rd_data_o == '0);

  p_inv_cfg_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    inv_o |=> $stable(cfg_q));

  p_split_idx_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_vld_o && bank) |-> sel_idx_o < IDXW'(NREG));

  p_cfg_nosel_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_en |-> !sel_vld_o);
endmodule

// File: tb/bank_addr_dec_tb.sv
module bank_addr_dec_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] strap_i;
  logic       start_i, byte_vld_i, rd_stb_i;
  logic [7:0] byte_i, rd_data_i;
  logic       sel_vld_o, sel_we_o, sel_port_o, rd_vld_o, inv_o;
  logic [3:0] sel_idx_o;
  logic [7:0] sel_wdata_o, rd_data_o, ptr_o, cfg_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic       c_vld, c_we, c_port, c_rvld, c_inv;
  logic [3:0] c_idx;
  logic [7:0] c_rdata;

  always #5 clk = ~clk;

  bank_addr_dec u_dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .start_i(start_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_stb_i(rd_stb_i),
    .rd_data_i(rd_data_i), .sel_vld_o(sel_vld_o), .sel_we_o(sel_we_o),
    .sel_port_o(sel_port_o), .sel_idx_o(sel_idx_o), .sel_wdata_o(sel_wdata_o),
    .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o), .inv_o(inv_o),
    .ptr_o(ptr_o), .cfg_o(cfg_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic capture();
    c_vld = sel_vld_o; c_we = sel_we_o; c_port = sel_port_o; c_idx = sel_idx_o;
    c_rvld = rd_vld_o; c_rdata = rd_data_o; c_inv = inv_o;
  endtask

  task automatic do_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    byte_vld_i = 1'b1; byte_i = b;
    #1 capture();
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic rd();
    rd_stb_i = 1'b1;
    #1 capture();
    @(negedge clk);
    rd_stb_i = 1'b0;
  endtask

  task automatic open_txn(input logic [7:0] ctrl, input logic [7:0] addr);
    do_start(); put(ctrl); put(addr);
  endtask

  task automatic t_reset();
    chk("R1 ptr after reset", ptr_o, 8'h00);
    chk("R1 cfg after reset", cfg_o, 8'h00);
    put(8'h40);
    chk("R1 no select before start", c_vld, 1'b0);
    chk("R1 ptr unchanged before start", ptr_o, 8'h00);
  endtask

  task automatic t_paired_write();
    open_txn(8'h40, 8'h00);
    chk("R12 ptr loaded", ptr_o, 8'h00);
    put(8'h11);
    chk("R2 0x00 vld/we", {c_vld, c_we}, 2'b11);
    chk("R2 0x00 port/idx", {c_port, c_idx}, {1'b0, 4'd0});
    put(8'h22);
    chk("R2 0x01 port/idx", {c_port, c_idx}, {1'b1, 4'd0});
    put(8'h33);
    chk("R2 0x02 port/idx", {c_port, c_idx}, {1'b0, 4'd1});
    chk("R6 ptr advanced", ptr_o, 8'h03);
    rd();
    chk("R11 strobe in write txn", {c_vld, c_rvld}, 2'b00);
    chk("R11 ptr kept", ptr_o, 8'h03);
  endtask

  task automatic t_paired_read();
    open_txn(8'h41, 8'h14);
    rd_data_i = 8'h5A;
    rd();
    chk("R10 rd 0x14 vld/we", {c_vld, c_we, c_rvld}, 3'b101);
    chk("R2 0x14 port/idx", {c_port, c_idx}, {1'b0, 4'd10});
    chk("R10 rd data", c_rdata, 8'h5A);
    rd();
    chk("R2 0x15 port/idx", {c_port, c_idx}, {1'b1, 4'd10});
    chk("R7 paired wrap", ptr_o, 8'h00);
    put(8'h77);
    chk("R11 byte in read txn", c_vld, 1'b0);
    chk("R11 ptr kept in read txn", ptr_o, 8'h00);
  endtask

  task automatic t_invalid();
    open_txn(8'h40, 8'h16);
    put(8'h99);
    chk("R8 invalid write flags", {c_inv, c_vld}, 2'b10);
    chk("R8 cfg untouched", cfg_o, 8'h00);
    open_txn(8'h41, 8'h20);
    rd_data_i = 8'hFF;
    rd();
    chk("R8 invalid read flags", {c_rvld, c_inv, c_vld}, 3'b110);
    chk("R8 invalid read zero", c_rdata, 8'h00);
  endtask

  task automatic t_bank_switch();
    open_txn(8'h40, 8'h0A);
    put(8'h80);
    chk("R4 cfg write no select", c_vld, 1'b0);
    chk("R4 cfg stored", cfg_o, 8'h80);
    chk("R5 ptr after switch", ptr_o, 8'h0B);
    put(8'h12);
    chk("R5 0x0B invalid in split", c_inv, 1'b1);
    for (int i = 0; i < 4; i++) put(8'h00);
    chk("R3 ptr reached 0x10", ptr_o, 8'h10);
    put(8'h34);
    chk("R3 0x10 port/idx", {c_vld, c_port, c_idx}, {1'b1, 1'b1, 4'd0});
    open_txn(8'h41, 8'h15);
    rd();
    chk("R4 cfg at 0x15", {c_vld, c_rvld, c_rdata}, {1'b0, 1'b1, 8'h80});
    open_txn(8'h41, 8'h05);
    rd();
    chk("R4 cfg at 0x05", c_rdata, 8'h80);
  endtask

  task automatic t_split_wrap();
    open_txn(8'h40, 8'h1A);
    put(8'h01);
    chk("R3 0x1A port/idx", {c_vld, c_port, c_idx}, {1'b1, 1'b1, 4'd10});
    chk("R7 split wrap", ptr_o, 8'h00);
  endtask

  task automatic t_hold();
    open_txn(8'h40, 8'h05);
    put(8'hA0);
    chk("R6 old setting used for this beat", ptr_o, 8'h06);
    open_txn(8'h40, 8'h03);
    for (int i = 0; i < 3; i++) begin
      put(8'h50);
      chk("R6 held target", {c_vld, c_port, c_idx}, {1'b1, 1'b0, 4'd3});
      chk("R6 ptr held", ptr_o, 8'h03);
    end
  endtask

  task automatic t_haen();
    strap_i = 3'd5;
    do_start(); put(8'h4A); put(8'h09);
    chk("R9 mismatch no load", ptr_o, 8'h03);
    put(8'h44);
    chk("R9 mismatch no access", c_vld, 1'b0);
    open_txn(8'h40, 8'h15);
    put(8'hA8);
    chk("R4 haen set", cfg_o, 8'hA8);
    do_start(); put(8'h40); put(8'h02); put(8'h66);
    chk("R9 zero address rejected", c_vld, 1'b0);
    chk("R9 ptr untouched", ptr_o, 8'h15);
    open_txn(8'h4A, 8'h02);
    put(8'h66);
    chk("R9 strap match", {c_vld, c_port, c_idx}, {1'b1, 1'b0, 4'd2});
    do_start(); put(8'h5A); put(8'h04); put(8'h66);
    chk("R9 wrong id", c_vld, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_i = 3'd0; start_i = 1'b0; byte_vld_i = 1'b0;
    byte_i = 8'h00; rd_stb_i = 1'b0; rd_data_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_paired_write();
    t_paired_read();
    t_invalid();
    t_bank_switch();
    t_split_wrap();
    t_hold();
    t_haen();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule